// File: doc/BRIEF.md
# Byte FIFO with Watermark Alerts

This block is a byte-wide first-in first-out buffer of 64 entries. It sits between a processor-facing register port and an internal data path. The data path writes bytes through a push port and reads them through a pop port. The processor sees the fill count, a sticky overflow flag and two watermark warnings, and it can empty the buffer with a self-clearing flush command.

One programmable threshold drives both warnings. The near-full warning compares the threshold with the free space, and the near-empty warning compares it with the occupancy. For each warning there is an enable bit. When the enable is set, a rising warning latches a request bit. Software clears a request by writing one to it. The interrupt line is high while a latched request and its warning are both true.

Register reads have no side effects. The read data is a combinational function of the register address.

Top module: `wmark_fifo`

## Requirements
- R1: After reset the fill count is 0, overflow is 0, enables, requests and threshold are 0, and `irq` is 0. The status register then reads 0x01, because the near-empty warning holds at count 0 with threshold 0.
- R2: Accepted pushes and pops keep first-in first-out order. Each accepted push raises the count (register 0x1, bits 6:0) by one, and each accepted pop lowers it by one. The count stays within 0..64.
- R3: A push while the count is 64 is discarded, even when a pop is requested in the same cycle. The stored bytes are unchanged. The overflow flag (register 0x5, bit 4) is set and stays set until a flush.
- R4: A pop while the count is 0 returns 0x00 on `dp_rdata` and leaves the count unchanged. A push in the same cycle is still accepted.
- R5: A push and a pop in the same cycle, with a count between 1 and 63, leave the count unchanged. The pop returns the oldest byte.
- R6: Writing 1 to register 0x4 bit 0 flushes the buffer in one cycle. The count goes to 0 and overflow is cleared. The flush wins over a push or pop in the same cycle. Register 0x4 always reads 0.
- R7: The near-full warning, status register 0x0 bit 1, is 1 exactly when 64 minus the count is less than or equal to the threshold.
- R8: The near-empty warning, status register 0x0 bit 0, is 1 exactly when the count is less than or equal to the threshold.
- R9: The threshold is register 0x6, bits 5:0. The enables are register 0x2, with bit 1 for near-full and bit 0 for near-empty. The requests are register 0x3, with the same bit order. A request is set on the edge after its warning rises, but only while its enable is 1. Writing 1 to a request bit clears it, and a new set in the same cycle wins over the clear.
- R10: `irq` is 1 exactly when some request bit is 1 and its warning is also 1.
- R11: Addresses 0x7 and any unlisted field bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dp_push | input | 1 | Push strobe from the data path |
| dp_wdata | input | 8 | Byte to push |
| dp_pop | input | 1 | Pop strobe from the data path |
| dp_rdata | output | 8 | Oldest byte, or 0x00 when empty |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request line |

## Verification
Register reads and `dp_rdata` are combinational. The bench samples them in the same half-cycle after setting the address, or before the edge that consumes a pop. The count, overflow flag and both warnings change on the edge that accepts the push, pop, flush or threshold write. The bench therefore reads them at the falling edge after that rising edge. A request bit and `irq` follow one edge later than the warning that triggers them, so the bench checks the request as still clear after the triggering operation and as set after one more idle cycle. The main sweep covers every threshold from 0 to 63 and every count from 0 to 64, and computes both warnings arithmetically.

// File: rtl/wmark_fifo_pkg.sv
package wmark_fifo_pkg;

   typedef enum logic [2:0] {
      RA_STATUS = 3'd0,
      RA_COUNT  = 3'd1,
      RA_IEN    = 3'd2,
      RA_IREQ   = 3'd3,
      RA_CTRL   = 3'd4,
      RA_ERR    = 3'd5,
      RA_LEVEL  = 3'd6
   } reg_addr_e;

   localparam int REG_W     = 8;
   localparam int NSRC      = 2;
   localparam int SRC_LO    = 0;
   localparam int SRC_HI    = 1;
   localparam int OVF_BIT   = 4;
   localparam int FLUSH_BIT = 0;

endpackage

// File: rtl/wmark_fifo_store.sv
module wmark_fifo_store #(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   input  logic          flush,
   output logic [DW-1:0] rdata,
   output logic [CW-1:0] count,
   output logic          ovf
);

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic          full, empty, acc_push, acc_pop;

   assign full     = (count == CW'(DEPTH));
   assign empty    = (count == '0);
   assign acc_push = push & ~full & ~flush;
   assign acc_pop  = pop & ~empty & ~flush;
   assign rdata    = empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (acc_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (acc_push) wr_ptr <= wr_ptr + 1'b1;
         if (acc_pop)  rd_ptr <= rd_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (flush) begin
         count <= '0;
      end else begin
         case ({acc_push, acc_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ovf <= 1'b0;
      else if (flush)          ovf <= 1'b0;
      else if (push && full)   ovf <= 1'b1;
   end

   a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   a_r3_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> (count == CW'(DEPTH)) && ovf);
   a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !flush) |=> ovf);
   a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push && !flush) |=> (count == '0));
   a_r5_push_pop_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && !full && push && pop && !flush) |=> $stable(count));
   a_r6_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0) && !ovf);

endmodule

// File: rtl/wmark_fifo_alerts.sv
module wmark_fifo_alerts
   import wmark_fifo_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int LW   = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CW-1:0]   count,
   input  logic [LW-1:0]   level,
   input  logic [NSRC-1:0] ien,
   input  logic [NSRC-1:0] clr,
   output logic [NSRC-1:0] alert,
   output logic [NSRC-1:0] req,
   output logic            irq
);

   logic [CW-1:0] free_cnt;

   assign free_cnt      = CW'(DEPTH) - count;
   assign alert[SRC_HI] = (free_cnt <= CW'(level));
   assign alert[SRC_LO] = (count <= CW'(level));
   assign irq           = |(req & alert);

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic prev;
      logic rise;

      assign rise = alert[i] & ~prev;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev   <= 1'b0;
            req[i] <= 1'b0;
         end else begin
            prev <= alert[i];
            if (rise && ien[i])   req[i] <= 1'b1;
            else if (clr[i])      req[i] <= 1'b0;
         end
      end

      a_r9_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(req[i]) |-> $past(ien[i]));
      a_r9_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (req[i] && !clr[i]) |=> req[i]);
   end

   a_r10_irq_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (req != '0));

endmodule

// File: rtl/wmark_fifo_regs.sv
module wmark_fifo_regs
   import wmark_fifo_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int LW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [2:0]       addr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   input  logic [CW-1:0]    count,
   input  logic             ovf,
   input  logic [NSRC-1:0]  alert,
   input  logic [NSRC-1:0]  req,
   output logic [NSRC-1:0]  ien,
   output logic [LW-1:0]    level,
   output logic [NSRC-1:0]  clr,
   output logic             flush
);

   reg_addr_e ra;

   assign ra    = reg_addr_e'(addr);
   assign flush = wr && (ra == RA_CTRL) && wdata[FLUSH_BIT];
   assign clr   = (wr && (ra == RA_IREQ)) ? wdata[NSRC-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien   <= '0;
         level <= '0;
      end else if (wr) begin
         if (ra == RA_IEN)   ien   <= wdata[NSRC-1:0];
         if (ra == RA_LEVEL) level <= wdata[LW-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      case (ra)
         RA_STATUS: rdata[NSRC-1:0] = alert;
         RA_COUNT:  rdata[CW-1:0]   = count;
         RA_IEN:    rdata[NSRC-1:0] = ien;
         RA_IREQ:   rdata[NSRC-1:0] = req;
         RA_ERR:    rdata[OVF_BIT]  = ovf;
         RA_LEVEL:  rdata[LW-1:0]   = level;
         default:   rdata = '0;
      endcase
   end

   a_r6_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ra == RA_CTRL) |-> (rdata == '0));

endmodule

// File: rtl/wmark_fifo.sv
module wmark_fifo
   import wmark_fifo_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int DW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dp_push,
   input  logic [DW-1:0]    dp_wdata,
   input  logic             dp_pop,
   output logic [DW-1:0]    dp_rdata,
   input  logic             reg_wr,
   input  logic [2:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             irq
);

   localparam int CW = $clog2(DEPTH + 1);
   localparam int LW = $clog2(DEPTH);

   if ((DEPTH < 4) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("wmark_fifo: DEPTH must be a power of two of at least 4");
   end
   if (CW > REG_W) begin : g_bad_cw
      $error("wmark_fifo: fill count does not fit one register");
   end
   if (DW < 1) begin : g_bad_dw
      $error("wmark_fifo: DW must be positive");
   end

   logic [CW-1:0]   count;
   logic            ovf, flush;
   logic [LW-1:0]   level;
   logic [NSRC-1:0] ien, clr, alert, req;

   wmark_fifo_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (dp_push),
      .wdata (dp_wdata),
      .pop   (dp_pop),
      .flush (flush),
      .rdata (dp_rdata),
      .count (count),
      .ovf   (ovf)
   );

   wmark_fifo_alerts #(.DEPTH(DEPTH)) alerts_i (
      .clk   (clk),
      .rst_n (rst_n),
      .count (count),
      .level (level),
      .ien   (ien),
      .clr   (clr),
      .alert (alert),
      .req   (req),
      .irq   (irq)
   );

   wmark_fifo_regs #(.DEPTH(DEPTH)) regs_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .rdata (reg_rdata),
      .count (count),
      .ovf   (ovf),
      .alert (alert),
      .req   (req),
      .ien   (ien),
      .level (level),
      .clr   (clr),
      .flush (flush)
   );

   a_r1_irq_low_in_reset: assert property (@(posedge clk)
      !rst_n |-> !irq);

endmodule

// File: tb/wmark_fifo_tb_top.sv
`timescale 1ns/1ps
module wmark_fifo_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dp_push = 1'b0, dp_pop = 1'b0, reg_wr = 1'b0;
   logic [7:0] dp_wdata = '0, dp_rdata, reg_wdata = '0, reg_rdata;
   logic [2:0] reg_addr = '0;
   logic       irq;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   wmark_fifo dut_i (
      .clk(clk), .rst_n(rst_n),
      .dp_push(dp_push), .dp_wdata(dp_wdata), .dp_pop(dp_pop), .dp_rdata(dp_rdata),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq)
   );

   task automatic chk(string rq, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", rq, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(int a, int d);
      reg_addr = 3'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic rd(int a, output int v);
      reg_addr = 3'(a);
      #0.5;
      v = int'(reg_rdata);
   endtask

   task automatic push(int d);
      dp_push = 1'b1; dp_wdata = 8'(d);
      tick();
      dp_push = 1'b0;
   endtask

   task automatic pop(output int v);
      dp_pop = 1'b1;
      #0.5;
      v = int'(dp_rdata);
      tick();
      dp_pop = 1'b0;
   endtask

   function automatic int pat(int l, int c);
      return (c * 37 + l * 11 + 5) & 255;
   endfunction

   function automatic int status_exp(int c, int l);
      return (((64 - c) <= l) ? 2 : 0) | ((c <= l) ? 1 : 0);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, R11 unmapped address
      rd(1, v); chk("R1 count", v, 0);
      rd(0, v); chk("R1 status", v, 1);
      rd(5, v); chk("R1 err", v, 0);
      rd(2, v); chk("R1 ien", v, 0);
      rd(3, v); chk("R1 ireq", v, 0);
      rd(6, v); chk("R1 level", v, 0);
      chk("R1 irq", int'(irq), 0);
      rd(7, v); chk("R11 unmapped", v, 0);

      // R2 R3 R4 R7 R8: sweep every threshold over every fill count
      for (int l = 0; l < 64; l++) begin
         wr(6, l);
         wr(4, 1);
         for (int c = 0; c <= 64; c++) begin
            rd(1, v); chk("R2 count", v, c);
            rd(0, v); chk("R7 R8 status", v, status_exp(c, l));
            if (c < 64) push(pat(l, c));
         end
         push(8'hAA);
         rd(1, v); chk("R3 count at full", v, 64);
         rd(5, v); chk("R3 ovf set", v, 8'h10);
         for (int c = 0; c < 64; c++) begin
            pop(v); chk("R2 R3 order", v, pat(l, c));
         end
         pop(v); chk("R4 empty data", v, 0);
         rd(1, v); chk("R4 empty count", v, 0);
         rd(5, v); chk("R3 ovf sticky", v, 8'h10);
         wr(4, 1);
         rd(5, v); chk("R6 ovf cleared", v, 0);
      end
      rd(4, v); chk("R6 ctrl reads 0", v, 0);

      // R5 simultaneous push/pop
      wr(6, 0);
      for (int c = 0; c < 5; c++) push(16 + c);
      dp_push = 1'b1; dp_wdata = 8'h77; dp_pop = 1'b1;
      #0.5; chk("R5 oldest", int'(dp_rdata), 16);
      tick(); dp_push = 1'b0; dp_pop = 1'b0;
      rd(1, v); chk("R5 count", v, 5);

      // R6 flush beats push
      reg_addr = 3'd4; reg_wdata = 8'h01; reg_wr = 1'b1; dp_push = 1'b1;
      tick(); reg_wr = 1'b0; dp_push = 1'b0;
      rd(1, v); chk("R6 flush wins", v, 0);

      // R4 push and pop at empty
      dp_push = 1'b1; dp_wdata = 8'h5C; dp_pop = 1'b1;
      #0.5; chk("R4 rdata empty", int'(dp_rdata), 0);
      tick(); dp_push = 1'b0; dp_pop = 1'b0;
      rd(1, v); chk("R4 push kept", v, 1);

      // R3 push with pop at full is still dropped
      wr(4, 1);
      for (int c = 0; c < 64; c++) push(c);
      dp_push = 1'b1; dp_wdata = 8'hEE; dp_pop = 1'b1;
      tick(); dp_push = 1'b0; dp_pop = 1'b0;
      rd(1, v); chk("R3 full push+pop", v, 63);
      rd(5, v); chk("R3 ovf push+pop", v, 8'h10);

      // R9 R10 near-empty request
      wr(4, 1);
      wr(6, 3);
      for (int c = 0; c < 5; c++) push(c);
      wr(3, 3);
      wr(2, 1);
      pop(v); pop(v);
      rd(3, v); chk("R9 req not yet", v, 0);
      chk("R10 irq not yet", int'(irq), 0);
      tick();
      rd(3, v); chk("R9 req lo set", v, 1);
      chk("R10 irq lo", int'(irq), 1);
      wr(3, 1);
      rd(3, v); chk("R9 w1c", v, 0);
      chk("R10 irq after clear", int'(irq), 0);
      wr(2, 0);
      push(9); pop(v); tick();
      rd(3, v); chk("R9 disabled no set", v, 0);

      // R9 R10 near-full request
      wr(4, 1);
      wr(2, 2);
      for (int c = 0; c < 61; c++) push(c);
      tick();
      rd(3, v); chk("R9 req hi set", v, 2);
      chk("R10 irq hi", int'(irq), 1);
      pop(v);
      chk("R10 irq drops with alert", int'(irq), 0);
      rd(3, v); chk("R9 req stays", v, 2);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule